// File: doc/BRIEF.md
# Receive Lane Error Counter and Status Bank

This block watches the receive side of a four-lane link and keeps a small bank of readable registers. For each lane it counts the code groups that the line decoder rejected. The count advances only while the lanes are reported as aligned. It stops at its top value and returns to zero whenever software reads it. Next to the counters sit two sticky status flags. The first remembers any collision in the lane-alignment FIFO. The second remembers any moment at which the lanes were not all in sync. A further read-only word shows the live 3-bit sync state of every lane.

Software reaches the bank through a plain read port: an address, a one-cycle read strobe and a combinational data word. Clearing a counter and releasing a flag happen on the clock edge that ends the strobe cycle, so the data seen during that cycle is the value from before the clear. Each sticky flag is driven by a two-state machine. In `LT_FOLLOW` the flag shows the live input. The transition *capture* moves it to `LT_HELD` when the input takes its reporting level (1 for the collision flag, 0 for the sync flag). In `LT_HELD` the flag is pinned at that level. The transition *release* returns it to `LT_FOLLOW` on a read of its address while the input is back at its idle level. A read during an ongoing event keeps the machine in `LT_HELD`.

Top module: `lane_err_stat_bank`

## Requirements
- R1: While `align_ok` is 1, each cycle with `dec_err[i]` high raises lane i's counter by exactly one.
- R2: While `align_ok` is 0, error strobes leave every counter unchanged.
- R3: A counter at 0xFFFF stays at 0xFFFF and does not wrap.
- R4: A read of a counter returns its value from before the read and leaves the counter at zero afterwards.
- R5: After reset every lane counter holds 0xFFFD.
- R6: Lane counters 0, 1, 2 and 3 are read at addresses 0x8010, 0x8011, 0x8012 and 0x8013.
- R7: Address 0x8015 bit 0 is the collision flag. It reads 1 from the cycle after `fifo_collide` is high until it is read, and after that read it follows `fifo_collide`. All other bits read 0.
- R8: Address 0x8016 bit 11 is the all-lanes sync flag. It reads 0 from the cycle after `all_sync` is low until it is read, and after that read it follows `all_sync`. All other bits read 0.
- R9: Address 0x8014 shows `lane_state` with lane 0 in bits 2:0, lane 1 in 5:3, lane 2 in 8:6 and lane 3 in 11:9. Bits 15:12 read 0.
- R10: If an error strobe and a read of the same counter fall in one cycle while counting is enabled and the counter is below 0xFFFF, the read returns the old value and the counter becomes 1.
- R11: A read of any other address returns 0 and changes no counter or flag. Counters and flags clear only on a strobe addressed to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_err | input | 4 | Per-lane undecodable code group strobe |
| align_ok | input | 1 | All lanes aligned; enables counting |
| fifo_collide | input | 1 | Lane-alignment FIFO collision, live |
| all_sync | input | 1 | All lanes synchronized, live |
| lane_state | input | 12 | Packed 3-bit sync state per lane, lane 0 lowest |
| rd_addr | input | 16 | Register read address |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |

## Verification
Two functions can fall in the same cycle: the error increment on a lane counter and the clear caused by reading that counter. The bench first builds a known count on lane 0. It then raises that lane's error strobe in the same cycle as the read strobe for 0x8010. It checks that the read returns the old count and that a second read returns 1, so the strike is neither lost nor merged into the cleared value. A similar pairing is made for the sticky flags, where a read during an ongoing event must keep the flag held.

// File: rtl/lesb_pkg.sv
package lesb_pkg;

    typedef enum logic {
        LT_FOLLOW = 1'b0,
        LT_HELD   = 1'b1
    } latch_state_e;

endpackage

// File: rtl/lesb_lane_ctr.sv
module lesb_lane_ctr #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err,
    input  logic             cnt_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             bump;

    assign bump = err && cnt_en && (cnt_q != CNT_MAX);

    always_comb begin
        if (clr) begin
            cnt_d = bump ? CNT_ONE : '0;
        end else if (bump) begin
            cnt_d = cnt_q + CNT_ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_ONE)); // R1
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr) |=> $stable(cnt)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(err && cnt_en)) |=> (cnt == '0)); // R4
    AST_READ_AND_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && err && cnt_en && cnt != CNT_MAX) |=> (cnt == CNT_ONE)); // R10

endmodule

// File: rtl/lesb_flag_latch.sv
module lesb_flag_latch
    import lesb_pkg::*;
#(
    parameter logic ACTIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic rd_clr,
    output logic flag
);

    latch_state_e state_q;
    latch_state_e state_d;
    logic         event_on;

    assign event_on = (live == ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_FOLLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_FOLLOW: if (event_on) state_d = LT_HELD;
            LT_HELD:   if (rd_clr && !event_on) state_d = LT_FOLLOW;
            default:   state_d = LT_FOLLOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LT_HELD:   flag = ACTIVE;
            LT_FOLLOW: flag = live;
            default:   flag = live;
        endcase
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_HELD && !rd_clr) |=> (flag == ACTIVE)); // R7
    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (live == ACTIVE) |=> (flag == ACTIVE)); // R8

endmodule

// File: rtl/lane_err_stat_bank.sv
module lane_err_stat_bank #(
    parameter int               NLANES     = 4,
    parameter int               DATA_W     = 16,
    parameter int               ADDR_W     = 16,
    parameter int               ST_W       = 3,
    parameter logic [ADDR_W-1:0] CNT_BASE   = 16'h8010,
    parameter logic [ADDR_W-1:0] STATE_ADDR = 16'h8014,
    parameter logic [ADDR_W-1:0] COLL_ADDR  = 16'h8015,
    parameter logic [ADDR_W-1:0] SYNC_ADDR  = 16'h8016,
    parameter int               SYNC_BIT   = 11,
    parameter logic [DATA_W-1:0] CNT_RST    = 16'hFFFD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLANES-1:0]      dec_err,
    input  logic                   align_ok,
    input  logic                   fifo_collide,
    input  logic                   all_sync,
    input  logic [NLANES*ST_W-1:0] lane_state,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_stb,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int STW_ALL = NLANES * ST_W;

    logic [DATA_W-1:0] lane_cnt [NLANES];
    logic [NLANES-1:0] lane_hit;
    logic              coll_flag;
    logic              sync_flag;
    logic              is_state;
    logic              is_coll;
    logic              is_sync;
    logic              mapped;

    assign is_state = (rd_addr == STATE_ADDR);
    assign is_coll  = (rd_addr == COLL_ADDR);
    assign is_sync  = (rd_addr == SYNC_ADDR);
    assign mapped   = (|lane_hit) || is_state || is_coll || is_sync;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign lane_hit[g] = (rd_addr == CNT_BASE + ADDR_W'(g));

        lesb_lane_ctr #(
            .CNT_W   (DATA_W),
            .RST_VAL (CNT_RST)
        ) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .err    (dec_err[g]),
            .cnt_en (align_ok),
            .clr    (rd_stb && lane_hit[g]),
            .cnt    (lane_cnt[g])
        );
    end

    lesb_flag_latch #(.ACTIVE(1'b1)) u_coll (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (fifo_collide),
        .rd_clr (rd_stb && is_coll),
        .flag   (coll_flag)
    );

    lesb_flag_latch #(.ACTIVE(1'b0)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (all_sync),
        .rd_clr (rd_stb && is_sync),
        .flag   (sync_flag)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (lane_hit[i]) rd_data = lane_cnt[i];
        end
        if (is_state) rd_data[STW_ALL-1:0] = lane_state;
        if (is_coll)  rd_data[0]           = coll_flag;
        if (is_sync)  rd_data[SYNC_BIT]    = sync_flag;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !mapped) |-> (rd_data == '0)); // R11
    AST_ONE_LANE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_hit)); // R6

endmodule

// File: tb/sim_lane_err_stat_bank.sv
`timescale 1ns/1ps
module sim_lane_err_stat_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dec_err = '0;
    logic        align_ok = 1'b0;
    logic        fifo_collide = 1'b0;
    logic        all_sync = 1'b1;
    logic [11:0] lane_state = '0;
    logic [15:0] rd_addr = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lane_err_stat_bank u0 (
        .clk(clk), .rst_n(rst_n), .dec_err(dec_err), .align_ok(align_ok),
        .fifo_collide(fifo_collide), .all_sync(all_sync), .lane_state(lane_state),
        .rd_addr(rd_addr), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
        rd_addr = 16'h0000;
    endtask

    task automatic pulse_err(input int lane, input int n);
        @(negedge clk);
        dec_err[lane] = 1'b1;
        repeat (n) @(negedge clk);
        dec_err[lane] = 1'b0;
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        align_ok = 1'b1;
        pulse_err(3, 4);
        rd(16'h8013, v); check("R3 lane3 sticks at max", v, 16'hFFFF);
        rd(16'h8013, v); check("R4 lane3 cleared", v, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int i = 0; i < 3; i++) begin
            rd(16'h8010 + 16'(i), v); check("R5 reset value", v, 16'hFFFD);
            rd(16'h8010 + 16'(i), v); check("R4 clear after read", v, 16'h0000);
        end
    endtask

    task automatic t_count();
        logic [15:0] v;
        align_ok = 1'b1;
        pulse_err(1, 5);
        rd(16'h8011, v); check("R1 R6 lane1 count", v, 16'd5);
        rd(16'h8012, v); check("R6 lane2 untouched", v, 16'd0);
        align_ok = 1'b0;
        pulse_err(2, 3);
        rd(16'h8012, v); check("R2 gated while unaligned", v, 16'd0);
        align_ok = 1'b1;
        pulse_err(2, 2);
        rd(16'h8012, v); check("R1 lane2 count", v, 16'd2);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        pulse_err(0, 3);
        @(negedge clk);
        dec_err[0] = 1'b1;
        rd_addr = 16'h8010;
        rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        dec_err[0] = 1'b0;
        rd_stb = 1'b0;
        check("R10 read returns old", v, 16'd3);
        rd(16'h8010, v); check("R10 strike kept as 1", v, 16'd1);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        rd(16'h8015, v); check("R7 idle reads 0", v, 16'h0000);
        @(negedge clk); fifo_collide = 1'b1;
        @(negedge clk); fifo_collide = 1'b0;
        rd(16'h8017, v); check("R11 unmapped 0x8017", v, 16'h0000);
        rd(16'h8015, v); check("R7 R11 latched high", v, 16'h0001);
        rd(16'h8015, v); check("R7 released", v, 16'h0000);
        fifo_collide = 1'b1;
        rd(16'h8015, v); check("R7 live high", v, 16'h0001);
        fifo_collide = 1'b0;
        rd(16'h8015, v); check("R7 held through read during event", v, 16'h0001);
        rd(16'h8015, v); check("R7 released after event", v, 16'h0000);
    endtask

    task automatic t_sync();
        logic [15:0] v;
        rd(16'h8016, v); check("R8 live sync", v, 16'h0800);
        @(negedge clk); all_sync = 1'b0;
        @(negedge clk); all_sync = 1'b1;
        rd(16'h8016, v); check("R8 latched low", v, 16'h0000);
        rd(16'h8016, v); check("R8 released", v, 16'h0800);
    endtask

    task automatic t_states();
        logic [15:0] v;
        lane_state = {3'd5, 3'd3, 3'd2, 3'd1};
        rd(16'h8014, v);
        check("R9 state fields", v, 16'((5 << 9) | (3 << 6) | (2 << 3) | 1));
        lane_state = 12'hFFF;
        rd(16'h8014, v); check("R9 upper bits zero", v, 16'h0FFF);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        pulse_err(1, 2);
        rd(16'h800F, v); check("R11 unmapped 0x800F", v, 16'h0000);
        rd(16'h9011, v); check("R11 unmapped 0x9011", v, 16'h0000);
        rd(16'h8011, v); check("R11 lane1 not cleared", v, 16'd2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_saturate();
        t_reset();
        t_count();
        t_same_cycle();
        t_collision();
        t_sync();
        t_states();
        t_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule